// File: doc/BRIEF.md
# Interrupt Pending and Vector Controller

This block records interrupt requests, one flag per vector number, and chooses which vector the core services next. Hardware sources raise a flag with a single-cycle pulse. Software reads all flags as one word at I/O word address 0x010 and writes that word back to withdraw requests. Software may raise only the debugger trap flag itself.

The core sends a strobe at the end of each instruction word. On that strobe the controller offers the lowest-numbered eligible pending vector and marks it as taken. Vectors 0 to 5 come from the program itself, so they are eligible in any mode. Vectors 6 to 15 come from devices and the debugger. They wait while the core runs system software (base and stack-extent registers both zero). They are taken at the end of the first instruction word that completes in user mode.

Top module: `irq_pend_ctrl`

## Requirements
- R1: After reset every pending flag is 0, the register reads 0x00000000 and `take_irq` is low.
- R2: A high `hw_req[i]` in a cycle sets flag i at the next clock edge, for i in 0..11 and 15. Requests on 12..14 are ignored. Bits 12..14 and 16..31 of the register always read 0.
- R3: With `bus_addr` equal to 0x010, `bus_rdata` returns the flags, with bit i holding vector i. Any other address reads 0.
- R4: A write to 0x010 clears each flag in 0..11 whose data bit is 0 and leaves the flag unchanged where the data bit is 1. Bit 15 takes the written value.
- R5: `take_irq` is high only in a cycle where `word_end` is high and an eligible flag is set. `take_vec` is then the lowest-numbered eligible flag.
- R6: While `sys_mode` is high, only vectors 0..5 are eligible. Flags 6..15 stay pending.
- R7: With `sys_mode` low, the first `word_end` takes any pending flag from 6..15.
- R8: The flag of a taken vector is 0 after the edge on which it was taken, unless `hw_req` for that vector is high in the same cycle. In that case the flag stays 1.
- R9: A write to any address other than 0x010 leaves every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_req | input | 16 | Per-vector request pulses |
| bus_addr | input | 12 | I/O word address for read and write |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| sys_mode | input | 1 | High while system software runs |
| word_end | input | 1 | Instruction-word boundary strobe |
| take_irq | output | 1 | Interrupt accepted at this boundary |
| take_vec | output | 4 | Vector number accepted |

## Verification
A wrong flag shows on `bus_rdata` in the same cycle, provided the address is 0x010. The bench keeps the address there on almost every cycle, so a wrong flag is caught one cycle after it occurs. A wrong eligibility or priority decision shows on `take_irq` and `take_vec` at the very next `word_end`. A missed automatic clear shows as a repeat of the same vector at the following boundary, and also as a stale bit on the readback. A behavioural model predicts both outputs every cycle.

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl #(
  parameter int VEC_N    = 16,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'h010,
  parameter int SYNC_N   = 6,
  parameter logic [VEC_N-1:0] IMPL_MASK = 16'h8FFF,
  parameter int DBG_BIT  = 15,
  localparam int VEC_W   = $clog2(VEC_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VEC_N-1:0]  hw_req,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sys_mode,
  input  logic              word_end,
  output logic              take_irq,
  output logic [VEC_W-1:0]  take_vec
);
  localparam logic [VEC_N-1:0] SYNC_MASK = VEC_N'((1 << SYNC_N) - 1);
  localparam logic [VEC_N-1:0] DBG_MASK  = VEC_N'(1) << DBG_BIT;

  logic [VEC_N-1:0] pend, pend_nx, elig, taken_oh;
  logic             any_elig;
  logic             reg_hit;

  assign reg_hit  = (bus_addr == REG_ADDR);
  assign elig     = pend & (sys_mode ? SYNC_MASK : IMPL_MASK);
  assign any_elig = |elig;
  assign take_irq = word_end & any_elig;

  always_comb begin
    take_vec = '0;
    for (int i = VEC_N - 1; i >= 0; i--)
      if (elig[i]) take_vec = VEC_W'(i);
  end

  assign taken_oh  = take_irq ? (VEC_N'(1) << take_vec) : '0;
  assign bus_rdata = reg_hit ? DATA_W'(pend) : '0;

  always_comb begin
    pend_nx = pend;
    if (bus_wr && reg_hit)
      pend_nx = (pend & bus_wdata[VEC_N-1:0] & ~DBG_MASK) | (bus_wdata[VEC_N-1:0] & DBG_MASK);
    pend_nx = ((pend_nx & ~taken_oh) | hw_req) & IMPL_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= pend_nx;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (pend == '0));

  assert_unimpl_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~IMPL_MASK) == '0);

  assert_req_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    |(hw_req & IMPL_MASK) |=> ((pend & $past(hw_req & IMPL_MASK)) == $past(hw_req & IMPL_MASK)));

  assert_sw_no_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(hw_req) & ~DBG_MASK) == '0));

  assert_take_on_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> word_end);

  assert_sys_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_irq && sys_mode) |-> (take_vec < VEC_W'(SYNC_N)));

  assert_take_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take_irq && !hw_req[take_vec]) |=> !pend[$past(take_vec)]);

  assert_req_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take_irq && hw_req[take_vec]) |=> pend[$past(take_vec)]);

  assert_foreign_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !reg_hit && !take_irq && hw_req == '0) |=> $stable(pend));
endmodule

// File: tb/irq_pend_ctrl_tb.sv
module irq_pend_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] hw_req = '0;
  logic [11:0] bus_addr = 12'h010;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sys_mode = 1'b1;
  logic        word_end = 1'b0;
  logic        take_irq;
  logic [3:0]  take_vec;

  int checks = 0;
  int fails = 0;
  string tag = "R1";
  logic [31:0] m_pend = '0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_pend_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sys_mode(sys_mode), .word_end(word_end), .take_irq(take_irq), .take_vec(take_vec)
  );

  function automatic int pick(input logic [31:0] p, input logic sm);
    logic [31:0] e;
    e = p & (sm ? 32'h0000_003F : 32'h0000_8FFF);
    for (int i = 0; i < 32; i++) if (e[i]) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    logic [31:0] n;
    int v;
    if (!rst_n) m_pend <= '0;
    else begin
      n = m_pend;
      if (bus_wr && bus_addr == 12'h010)
        n = (n & bus_wdata & 32'h0000_0FFF) | (bus_wdata & 32'h0000_8000);
      v = pick(m_pend, sys_mode);
      if (word_end && v >= 0) n[v] = 1'b0;
      n = (n | {16'h0, hw_req}) & 32'h0000_8FFF;
      m_pend <= n;
    end
  end

  always @(negedge clk) begin
    logic [31:0] exp_rd;
    int v;
    logic exp_take;
    exp_rd = (bus_addr == 12'h010) ? m_pend : 32'h0;
    v = pick(m_pend, sys_mode);
    exp_take = word_end && v >= 0;
    checks++;
    if (bus_rdata !== exp_rd) begin
      fails++;
      $display("FAIL %s rdata actual=%h expected=%h", tag, bus_rdata, exp_rd);
    end
    checks++;
    if (take_irq !== exp_take) begin
      fails++;
      $display("FAIL %s take_irq actual=%b expected=%b", tag, take_irq, exp_take);
    end
    if (exp_take) begin
      checks++;
      if (take_vec !== 4'(v)) begin
        fails++;
        $display("FAIL %s take_vec actual=%0d expected=%0d", tag, take_vec, v);
      end
    end
  end

  task automatic step(input logic [15:0] hr, input logic wr, input logic [11:0] a,
                      input logic [31:0] wd, input logic sm, input logic we);
    hw_req = hr; bus_wr = wr; bus_addr = a; bus_wdata = wd; sys_mode = sm; word_end = we;
    @(posedge clk); #1;
    hw_req = '0; bus_wr = 1'b0; word_end = 1'b0; bus_addr = 12'h010;
  endtask

  task automatic expect_pend(input logic [31:0] e, input string t);
    @(negedge clk);
    checks++;
    if (bus_rdata !== e) begin
      fails++;
      $display("FAIL %s directed rdata actual=%h expected=%h", t, bus_rdata, e);
    end
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    expect_pend(32'h0, "R1");
    rst_n = 1'b1;
    tag = "R2";
    step(16'h0040, 0, 12'h010, 0, 1, 0);
    expect_pend(32'h0000_0040, "R2");
    step(16'hF000, 0, 12'h010, 0, 1, 0);
    expect_pend(32'h0000_8040, "R2");
    tag = "R3";
    step(16'h0000, 0, 12'h011, 0, 1, 0);
    step(16'h0000, 0, 12'h000, 0, 1, 0);
    tag = "R4";
    step(16'h0FFF, 0, 12'h010, 0, 1, 0);
    step(16'h0000, 1, 12'h010, 32'h0000_0F0F, 1, 0);
    expect_pend(32'h0000_0F0F, "R4");
    step(16'h0000, 1, 12'h010, 32'hFFFF_F0F0, 1, 0);
    expect_pend(32'h0000_8000, "R4");
    step(16'h0000, 1, 12'h010, 32'h0000_0000, 1, 0);
    expect_pend(32'h0, "R4");
    step(16'h0000, 1, 12'h010, 32'h0000_8000, 1, 0);
    expect_pend(32'h0000_8000, "R4");
    tag = "R9";
    step(16'h0000, 1, 12'h020, 32'h0, 1, 0);
    expect_pend(32'h0000_8000, "R9");
    tag = "R6";
    step(16'h0440, 0, 12'h010, 0, 1, 0);
    step(16'h0000, 0, 12'h010, 0, 1, 1);
    expect_pend(32'h0000_8440, "R6");
    step(16'h0028, 0, 12'h010, 0, 1, 0);
    step(16'h0000, 0, 12'h010, 0, 1, 1);
    step(16'h0000, 0, 12'h010, 0, 1, 1);
    step(16'h0000, 0, 12'h010, 0, 1, 1);
    expect_pend(32'h0000_8440, "R6");
    tag = "R7";
    step(16'h0000, 0, 12'h010, 0, 0, 0);
    step(16'h0000, 0, 12'h010, 0, 0, 1);
    expect_pend(32'h0000_8400, "R7");
    tag = "R8";
    step(16'h0400, 0, 12'h010, 0, 0, 1);
    expect_pend(32'h0000_8400, "R8");
    step(16'h0000, 0, 12'h010, 0, 0, 1);
    step(16'h0000, 0, 12'h010, 0, 0, 1);
    expect_pend(32'h0, "R8");
    tag = "R5";
    step(16'h0214, 0, 12'h010, 0, 0, 0);
    for (int k = 0; k < 4; k++) step(16'h0000, 0, 12'h010, 0, 0, 1);
    expect_pend(32'h0, "R5");
    step(16'h8801, 0, 12'h010, 0, 0, 0);
    step(16'h0000, 0, 12'h010, 0, 1, 1);
    step(16'h0000, 0, 12'h010, 0, 0, 1);
    step(16'h0000, 0, 12'h010, 0, 0, 1);
    expect_pend(32'h0, "R5");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule